// File: doc/BRIEF.md
# Per-Pixel Hit Time Recorder

This block is the digital store of a single sensor pixel. Every pixel in an array shares a 14-bit time-code bus. When the pixel's discriminator fires during a bunch train, the block keeps the current bus value in a small local store and moves its write pointer on, so a second hit in the same train goes into the next cell. When every cell is occupied, further hits in that train are dropped and a sticky overflow flag is raised.

Between trains the stored codes leave through a simple read port. The oldest unread code is shown together with a valid flag, and a one-cycle acknowledge consumes it. A pixel with nothing left to give raises an empty flag, so an array-level scanner can skip it at once. A one-cycle train-start pulse discards everything left over from the previous train.

The strobe from the discriminator is asynchronous. It passes through a two-stage synchroniser and an edge detector, so a strobe held high counts as one hit.

Top module: `pixel_stamp_recorder`

## Requirements
- R1: After reset, with `train_active` low, `empty` is 1, `rd_valid` is 0 and `overflow` is 0.
- R2: A rising edge on `hit_strobe` during a train records the `stamp_bus` value present at the third rising clock edge after the strobe goes high. A strobe held high records only once. A stored code does not change when the bus changes later.
- R3: Hits in one train fill cell 0 and then cell 1. Readout presents the codes in capture order, oldest first.
- R4: Strobe edges while `train_active` is 0 store nothing.
- R5: A hit that arrives while both cells are full is dropped. The stored codes stay unchanged, and `overflow` goes to 1 and stays at 1 until the next `train_start`.
- R6: A `train_start` pulse clears all cells, both pointers and `overflow`.
- R7: While `train_active` is 1, `rd_valid` and `empty` are 0 and `rd_ack` has no effect.
- R8: Outside a train, `rd_ack` while `rd_valid` is 1 consumes the shown code. `empty` becomes 1 once no unread code remains. `rd_ack` while `empty` is 1 changes nothing.
- R9: Two strobe pulses are both recorded, with their own codes, when the strobe stays high for two clock cycles and then low for two clock cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_active | input | 1 | High for the duration of a bunch train |
| train_start | input | 1 | One-cycle pulse that clears the store for a new train |
| hit_strobe | input | 1 | Asynchronous discriminator output |
| stamp_bus | input | 14 | Shared time-code bus |
| rd_ack | input | 1 | Consumes the code currently shown |
| rd_stamp | output | 14 | Oldest unread code, zero when `rd_valid` is low |
| rd_valid | output | 1 | `rd_stamp` holds an unread code (only between trains) |
| empty | output | 1 | No unread code remains (only between trains) |
| overflow | output | 1 | A hit was dropped in the current train |

## Verification
On every cycle the assertions check the following: the write count never exceeds the cell count, overflow stays set until a train start, a train start leaves the pointers and flag cleared, the write pointer does not move outside a train, a stored code stays fixed while its cell is valid, and the edge detector never emits two pulses in a row. Only the bench scenarios can show which bus value ends up in which cell. The same holds for the readout order, the effect of a held strobe, ignored acknowledges during trains and on an empty pixel, and the spacing at which two close hits are both kept.

// File: rtl/stamp_pkg.sv
`timescale 1ns/1ps
package stamp_pkg;
    localparam int STAMP_W      = 14;
    localparam int CELLS_DFLT   = 2;
    localparam int SYNC_DFLT    = 2;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        logic   valid;
        stamp_t stamp;
    } cell_t;

    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/stamp_hit_sync.sv
`timescale 1ns/1ps
module stamp_hit_sync #(
    parameter int STAGES = stamp_pkg::SYNC_DFLT
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic hit_pulse
);
    // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], strobe_async};
    end

    assign hit_pulse = chain[STAGES-1] & ~chain[STAGES];

    // R2
    hit_single_chk: assert property (@(posedge clk) disable iff (rst)
        hit_pulse |=> !hit_pulse);
endmodule

// File: rtl/stamp_ptr_ctrl.sv
`timescale 1ns/1ps
module stamp_ptr_ctrl #(
    parameter int N_CELLS = stamp_pkg::CELLS_DFLT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               train_start,
    input  logic               train_active,
    input  logic               hit_pulse,
    input  logic               rd_ack,
    input  logic [N_CELLS-1:0] cell_valid,
    output logic               wr_en,
    output logic [N_CELLS-1:0] wr_sel,
    output logic [N_CELLS-1:0] rd_sel,
    output logic               consume,
    output logic               rd_valid,
    output logic               empty,
    output logic               overflow
);
    localparam int CNT_W = stamp_pkg::count_width(N_CELLS);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(N_CELLS);

    logic [CNT_W-1:0] wr_cnt, rd_cnt;
    logic accept, drop;

    always_comb begin
        wr_sel = '0;
        rd_sel = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (wr_cnt == CNT_W'(i)) wr_sel[i] = 1'b1;
            if (rd_cnt == CNT_W'(i)) rd_sel[i] = 1'b1;
        end
    end

    assign accept   = hit_pulse && train_active && !train_start;
    assign wr_en    = accept && (wr_cnt < FULL);
    assign drop     = accept && (wr_cnt == FULL);
    assign rd_valid = !train_active && |(rd_sel & cell_valid);
    assign empty    = !train_active && !(|cell_valid);
    assign consume  = rd_ack && rd_valid && !train_start;

    always_ff @(posedge clk) begin
        if (rst || train_start) begin
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_en)   wr_cnt   <= wr_cnt + 1'b1;
            if (drop)    overflow <= 1'b1;
            if (consume) rd_cnt   <= rd_cnt + 1'b1;
        end
    end

    // R5
    wr_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= FULL);
    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !train_start) |=> overflow);
    // R6
    train_clear_chk: assert property (@(posedge clk) disable iff (rst)
        train_start |=> (wr_cnt == '0 && rd_cnt == '0 && !overflow));
    // R4
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!train_active && !train_start) |=> $stable(wr_cnt));
endmodule

// File: rtl/stamp_cell_bank.sv
`timescale 1ns/1ps
module stamp_cell_bank #(
    parameter int N_CELLS = stamp_pkg::CELLS_DFLT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clear,
    input  logic                             wr_en,
    input  logic [N_CELLS-1:0]               wr_sel,
    input  stamp_pkg::stamp_t                stamp_in,
    input  logic                             consume,
    input  logic [N_CELLS-1:0]               rd_sel,
    output stamp_pkg::cell_t [N_CELLS-1:0]   cells
);
    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cells[g] <= '0;
            end else if (wr_en && wr_sel[g]) begin
                cells[g].valid <= 1'b1;
                cells[g].stamp <= stamp_in;
            end else if (consume && rd_sel[g]) begin
                cells[g].valid <= 1'b0;
            end
        end

        // R2
        stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cells[g].valid && !clear && !(wr_en && wr_sel[g]))
                |=> $stable(cells[g].stamp));
    end
endmodule

// File: rtl/pixel_stamp_recorder.sv
`timescale 1ns/1ps
module pixel_stamp_recorder #(
    parameter int N_CELLS     = stamp_pkg::CELLS_DFLT,
    parameter int SYNC_STAGES = stamp_pkg::SYNC_DFLT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         train_active,
    input  logic                         train_start,
    input  logic                         hit_strobe,
    input  logic [stamp_pkg::STAMP_W-1:0] stamp_bus,
    input  logic                         rd_ack,
    output logic [stamp_pkg::STAMP_W-1:0] rd_stamp,
    output logic                         rd_valid,
    output logic                         empty,
    output logic                         overflow
);
    import stamp_pkg::*;

    logic               hit_pulse, wr_en, consume;
    logic [N_CELLS-1:0] wr_sel, rd_sel, cell_valid;
    cell_t [N_CELLS-1:0] cells;

    stamp_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .strobe_async(hit_strobe), .hit_pulse(hit_pulse)
    );

    stamp_ptr_ctrl #(.N_CELLS(N_CELLS)) u_ctrl (
        .clk(clk), .rst(rst), .train_start(train_start),
        .train_active(train_active), .hit_pulse(hit_pulse), .rd_ack(rd_ack),
        .cell_valid(cell_valid), .wr_en(wr_en), .wr_sel(wr_sel),
        .rd_sel(rd_sel), .consume(consume), .rd_valid(rd_valid),
        .empty(empty), .overflow(overflow)
    );

    stamp_cell_bank #(.N_CELLS(N_CELLS)) u_bank (
        .clk(clk), .rst(rst), .clear(train_start), .wr_en(wr_en),
        .wr_sel(wr_sel), .stamp_in(stamp_bus), .consume(consume),
        .rd_sel(rd_sel), .cells(cells)
    );

    always_comb begin
        rd_stamp = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            cell_valid[i] = cells[i].valid;
            if (rd_valid && rd_sel[i]) rd_stamp = rd_stamp | cells[i].stamp;
        end
    end

    // R7
    no_read_in_train_chk: assert property (@(posedge clk) disable iff (rst)
        train_active |-> $stable(cell_valid) || $past(train_start) || $past(wr_en));
endmodule

// File: tb/tb_pixel_stamp_recorder.sv
`timescale 1ns/1ps
module tb_pixel_stamp_recorder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        train_active = 1'b0;
    logic        train_start = 1'b0;
    logic        hit_strobe = 1'b0;
    logic [13:0] stamp_bus = '0;
    logic        rd_ack = 1'b0;
    logic [13:0] rd_stamp;
    logic        rd_valid, empty, overflow;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pixel_stamp_recorder dut (
        .clk(clk), .rst(rst), .train_active(train_active),
        .train_start(train_start), .hit_strobe(hit_strobe),
        .stamp_bus(stamp_bus), .rd_ack(rd_ack), .rd_stamp(rd_stamp),
        .rd_valid(rd_valid), .empty(empty), .overflow(overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #0.1;
    endtask

    task automatic begin_train();
        @(negedge clk); train_start = 1'b1; train_active = 1'b1;
        @(negedge clk); train_start = 1'b0;
    endtask

    task automatic end_train();
        @(negedge clk); train_active = 1'b0;
        #0.1;
    endtask

    task automatic hit(input logic [13:0] v, input int high);
        @(negedge clk); stamp_bus = v; hit_strobe = 1'b1;
        repeat (high) @(negedge clk);
        hit_strobe = 1'b0;
        repeat (4) @(negedge clk);
        stamp_bus = ~v;
    endtask

    task automatic read_one(input string req, input logic [13:0] exp);
        #0.1;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " rd_stamp"}, int'(rd_stamp), int'(exp));
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        #0.1;
    endtask

    task automatic t_reset();
        cyc(1);
        check("R1 empty", int'(empty), 1);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_single();
        begin_train();
        hit(14'h1234, 1);
        #0.1;
        check("R7 rd_valid in train", int'(rd_valid), 0);
        check("R7 empty in train", int'(empty), 0);
        end_train();
        read_one("R2 single", 14'h1234);
        check("R8 empty after read", int'(empty), 1);
    endtask

    task automatic t_order();
        begin_train();
        hit(14'h0011, 1);
        hit(14'h2A5C, 1);
        end_train();
        read_one("R3 first", 14'h0011);
        read_one("R3 second", 14'h2A5C);
        check("R3 empty", int'(empty), 1);
    endtask

    task automatic t_held();
        begin_train();
        hit(14'h0777, 10);
        end_train();
        read_one("R2 held", 14'h0777);
        check("R2 held single record", int'(empty), 1);
    endtask

    task automatic t_idle();
        hit(14'h0100, 2);
        #0.1;
        check("R4 idle hit empty", int'(empty), 1);
        check("R4 idle hit rd_valid", int'(rd_valid), 0);
    endtask

    task automatic t_overflow();
        begin_train();
        hit(14'h0A01, 1);
        hit(14'h0B02, 1);
        #0.1;
        check("R5 no overflow yet", int'(overflow), 0);
        hit(14'h0C03, 1);
        #0.1;
        check("R5 overflow set", int'(overflow), 1);
        end_train();
        read_one("R5 cell0", 14'h0A01);
        read_one("R5 cell1", 14'h0B02);
        check("R5 third dropped", int'(empty), 1);
        check("R5 overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_clear();
        begin_train();
        #0.1;
        check("R6 overflow cleared", int'(overflow), 0);
        hit(14'h0321, 1);
        hit(14'h0654, 1);
        end_train();
        read_one("R6 partial read", 14'h0321);
        begin_train();
        end_train();
        check("R6 leftover cleared", int'(empty), 1);
        check("R6 leftover rd_valid", int'(rd_valid), 0);
    endtask

    task automatic t_ack_in_train();
        begin_train();
        hit(14'h0AAA, 1);
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        end_train();
        read_one("R7 ack in train ignored", 14'h0AAA);
    endtask

    task automatic t_ack_empty();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        begin_train();
        hit(14'h1E1E, 1);
        hit(14'h2F2F, 1);
        end_train();
        read_one("R8 after empty ack first", 14'h1E1E);
        read_one("R8 after empty ack second", 14'h2F2F);
        check("R8 empty", int'(empty), 1);
    endtask

    task automatic t_fast();
        begin_train();
        @(negedge clk); stamp_bus = 14'h0123; hit_strobe = 1'b1;
        repeat (2) @(negedge clk); hit_strobe = 1'b0;
        repeat (2) @(negedge clk); stamp_bus = 14'h3210; hit_strobe = 1'b1;
        repeat (2) @(negedge clk); hit_strobe = 1'b0;
        repeat (4) @(negedge clk);
        end_train();
        read_one("R9 fast first", 14'h0123);
        read_one("R9 fast second", 14'h3210);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_order();
        t_held();
        t_idle();
        t_overflow();
        t_clear();
        t_ack_in_train();
        t_ack_empty();
        t_fast();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule